// File: doc/BRIEF.md
# Stored-Operand NAND Evaluation Sequencer

This block sequences a single-device, non-volatile dynamic NAND cell. The cell holds one operand (B) as a persistent bit. The second operand (A) is presented as a gate level only while an evaluation is in progress. The block contains a cycle-level behavioural model of that cell: a stored bit, which changes only through polarity-coded write pulses, and an output node, which is precharged high and discharged when the device conducts. Around the model sits a controller. It accepts one command at a time and walks the cell through its steps in a fixed order. It then reports the sampled node with a one-cycle valid strobe.

A command carries two flags. The write flag replaces the stored operand. The evaluate flag runs precharge, activate and apply, followed by a result cycle. Both flags may be set together, in which case the write goes first. Every step lasts `STEP_CYC` clock cycles.

Two resets are provided. A power-on reset clears the cell model. The controller reset leaves the stored bit untouched. The first time after power-up, the controller conditions the device with two opposite write pulses before it lets any command run.

Top module: `sonand_seq`

## Requirements
- R1: When a command with the evaluate flag completes, `res_valid` is 1 for exactly one cycle. In that cycle `res_data` equals NOT(A AND B), where A is the command's `cmd_a` and B is the stored bit after any write carried by the same command.
- R2: An accepted command drives its steps back to back, each exactly `STEP_CYC` cycles long: write (only when `cmd_wr`=1), then precharge, activate and apply (only when `cmd_ev`=1), then one result cycle.
- R3: During precharge `drv_pu`=1 and `drv_pd`=0. During activate and apply `drv_pu`=0 and `drv_pd`=1. In every other state both are 0.
- R4: A write of B=1 asserts `drv_wneg` (negative pulse) for the whole write step. A write of B=0 asserts `drv_wpos` (positive pulse). The two are never high together.
- R5: After power-on reset the block first drives `drv_wneg` for `STEP_CYC` cycles and then `drv_wpos` for `STEP_CYC` cycles. This leaves B=0.
- R6: The output node is set to 1 by precharge. It falls to 0 only when the device is activated with A=1 while B=1. Otherwise it keeps its value.
- R7: `busy` goes high in the cycle after a command is accepted and stays high through the result cycle, then falls. Commands presented while `busy` is high are ignored.
- R8: The stored bit keeps its value across evaluations and across the controller reset `rst_n`. Only a write step changes it, and the conditioning pulses are not repeated after `rst_n`.
- R9: A command presented during conditioning is accepted and held. It starts only after both conditioning pulses are done.
- R10: A command with neither `cmd_wr` nor `cmd_ev` set is not accepted and causes no activity.
- R11: `drv_a` carries `cmd_a` only during the apply step and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the cell model and the controller |
| rst_n | input | 1 | Synchronous controller reset, active low; the stored bit survives it |
| cmd_valid | input | 1 | Command present |
| cmd_wr | input | 1 | Command writes the stored operand |
| cmd_b | input | 1 | Value to store when `cmd_wr` is set |
| cmd_ev | input | 1 | Command evaluates with a live operand |
| cmd_a | input | 1 | Live operand A |
| busy | output | 1 | Command in progress |
| res_valid | output | 1 | Evaluation result strobe |
| res_data | output | 1 | Sampled output node, 0 when not valid |
| drv_pu | output | 1 | Pull-up (precharge) control to the cell |
| drv_pd | output | 1 | Pull-down (activate) control to the cell |
| drv_a | output | 1 | Gate level for operand A |
| drv_wneg | output | 1 | Negative write pulse (stores 1) |
| drv_wpos | output | 1 | Positive write pulse (stores 0) |

## Verification
The bench builds the block with `STEP_CYC` = 3, not the default 2. At that length an off-by-one in the step counter changes the per-cycle drive pattern that the reference checks. With three cycles per step, the conditioning sequence is six pulse cycles long, which leaves room to present a held-off command mid-sequence. It also shows whether any precharge leaks in before the positive pulse has finished. The run toggles only `rst_n` after B has been set to 1, so preservation of the stored bit and the skipped re-conditioning both become visible at the result port.

// File: rtl/sonand_pkg.sv
package sonand_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_N,
        ST_INIT_P,
        ST_WRITE,
        ST_PRE,
        ST_ACT,
        ST_APPLY,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic wr;
        logic b;
        logic ev;
        logic a;
    } cmd_t;

    typedef struct packed {
        logic pu;
        logic pd;
        logic a;
        logic wneg;
        logic wpos;
    } drive_t;

endpackage

// File: rtl/sonand_step_timer.sv
module sonand_step_timer #(
    parameter int STEP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = run && (cnt_q == LAST_V);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || last) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a step never runs past its programmed length
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V);

endmodule

// File: rtl/sonand_cell.sv
module sonand_cell
    import sonand_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  drive_t drv,
    output logic   stored,
    output logic   node,
    output logic   ready
);
    typedef struct packed {
        logic stored;
        logic node;
        logic seen;
        logic last_neg;
        logic ready;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (drv.wneg || drv.wpos) begin
            c_d.stored   = drv.wneg;
            if (c_q.seen && (c_q.last_neg != drv.wneg)) c_d.ready = 1'b1;
            c_d.seen     = 1'b1;
            c_d.last_neg = drv.wneg;
        end
        if (drv.pu && !drv.pd)
            c_d.node = 1'b1;
        else if (!drv.pu && drv.pd && drv.a && c_q.stored)
            c_d.node = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!por_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign stored = c_q.stored;
    assign node   = c_q.node;
    assign ready  = c_q.ready;

    // R4: both write polarities at once is illegal
    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!por_n)
        !(drv.wneg && drv.wpos));
    // R6: the node discharges only through a conducting device
    p_node_fall_r6: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(c_q.node)) |-> $past(drv.pd && !drv.pu && drv.a && c_q.stored));
    // R8: the stored bit moves only under a write pulse
    p_stored_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        (c_q.stored != $past(c_q.stored)) |-> $past(drv.wneg || drv.wpos));

endmodule

// File: rtl/sonand_ctrl.sv
module sonand_ctrl
    import sonand_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  cmd_t   cmd_in,
    input  logic   cell_ready,
    input  logic   cell_node,
    input  logic   step_last,
    output logic   step_run,
    output drive_t drv,
    output logic   busy,
    output logic   res_valid,
    output logic   res_data
);
    typedef struct packed {
        seq_st_e st;
        logic    pend;
        cmd_t    cmd;
    } ctl_t;

    ctl_t s_d, s_q;
    logic accept;
    cmd_t cur;

    always_comb begin
        s_d    = s_q;
        accept = cmd_valid && (cmd_in.wr || cmd_in.ev) && !s_q.pend;
        cur    = s_q.pend ? s_q.cmd : cmd_in;
        if (accept) begin
            s_d.pend = 1'b1;
            s_d.cmd  = cmd_in;
        end
        case (s_q.st)
            ST_IDLE: begin
                if (!cell_ready)               s_d.st = ST_INIT_N;
                else if (s_q.pend || accept)   s_d.st = cur.wr ? ST_WRITE : ST_PRE;
            end
            ST_INIT_N: if (step_last) s_d.st = ST_INIT_P;
            ST_INIT_P: if (step_last) s_d.st = ST_IDLE;
            ST_WRITE:  if (step_last) s_d.st = s_q.cmd.ev ? ST_PRE : ST_DONE;
            ST_PRE:    if (step_last) s_d.st = ST_ACT;
            ST_ACT:    if (step_last) s_d.st = ST_APPLY;
            ST_APPLY:  if (step_last) s_d.st = ST_DONE;
            ST_DONE: begin
                s_d.st   = ST_IDLE;
                s_d.pend = 1'b0;
            end
            default:   s_d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        drv = '0;
        case (s_q.st)
            ST_INIT_N: drv.wneg = 1'b1;
            ST_INIT_P: drv.wpos = 1'b1;
            ST_WRITE: begin
                drv.wneg = s_q.cmd.b;
                drv.wpos = !s_q.cmd.b;
            end
            ST_PRE:    drv.pu = 1'b1;
            ST_ACT:    drv.pd = 1'b1;
            ST_APPLY: begin
                drv.pd = 1'b1;
                drv.a  = s_q.cmd.a;
            end
            default: ;
        endcase
    end

    assign step_run  = (s_q.st != ST_IDLE) && (s_q.st != ST_DONE);
    assign busy      = s_q.pend;
    assign res_valid = (s_q.st == ST_DONE) && s_q.cmd.ev;
    assign res_data  = res_valid && cell_node;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.pend <= 1'b0;
            s_q.cmd  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: a result is only reported inside a busy window
    p_res_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);
    // R11: operand A reaches the gate only while the device is activated
    p_gate_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drv.a |-> (drv.pd && !drv.pu));
    // R9: no command step starts on an unconditioned device
    p_start_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_PRE || s_q.st == ST_WRITE) && $past(s_q.st) == ST_IDLE)
            |-> $past(cell_ready));
    // R2: activation always follows a precharge
    p_pre_then_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.st == ST_ACT) |-> $past(s_q.st) == ST_PRE);

endmodule

// File: rtl/sonand_seq.sv
module sonand_seq
    import sonand_pkg::*;
#(
    parameter int STEP_CYC = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_wr,
    input  logic cmd_b,
    input  logic cmd_ev,
    input  logic cmd_a,
    output logic busy,
    output logic res_valid,
    output logic res_data,
    output logic drv_pu,
    output logic drv_pd,
    output logic drv_a,
    output logic drv_wneg,
    output logic drv_wpos
);
    cmd_t   cmd_in;
    drive_t drv;
    logic   ctl_rst_n;
    logic   step_run, step_last;
    logic   cell_stored, cell_node, cell_ready;

    assign cmd_in    = '{wr: cmd_wr, b: cmd_b, ev: cmd_ev, a: cmd_a};
    assign ctl_rst_n = rst_n && por_n;

    sonand_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk   (clk),
        .rst_n (ctl_rst_n),
        .run   (step_run),
        .last  (step_last)
    );

    sonand_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (ctl_rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_in     (cmd_in),
        .cell_ready (cell_ready),
        .cell_node  (cell_node),
        .step_last  (step_last),
        .step_run   (step_run),
        .drv        (drv),
        .busy       (busy),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    sonand_cell u_cell (
        .clk    (clk),
        .por_n  (por_n),
        .drv    (drv),
        .stored (cell_stored),
        .node   (cell_node),
        .ready  (cell_ready)
    );

    assign drv_pu   = drv.pu;
    assign drv_pd   = drv.pd;
    assign drv_a    = drv.a;
    assign drv_wneg = drv.wneg;
    assign drv_wpos = drv.wpos;

    // R1: a strobed result is the NAND of the applied and stored operands
    p_nand_r1: assert property (@(posedge clk) disable iff (!ctl_rst_n)
        (res_valid && !res_data) |-> cell_stored);

endmodule

// File: tb/sonand_seq_tb.sv
module sonand_seq_tb;
    localparam int S = 3;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_wr = 1'b0, cmd_b = 1'b0, cmd_ev = 1'b0, cmd_a = 1'b0;
    logic busy, res_valid, res_data, drv_pu, drv_pd, drv_a, drv_wneg, drv_wpos;

    int checks = 0;
    int errors = 0;
    logic model_b = 1'b0;

    always #2 clk = ~clk;

    sonand_seq #(.STEP_CYC(S)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_b(cmd_b),
        .cmd_ev(cmd_ev), .cmd_a(cmd_a),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .drv_pu(drv_pu), .drv_pd(drv_pd), .drv_a(drv_a),
        .drv_wneg(drv_wneg), .drv_wpos(drv_wpos)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_quiet(string req);
        chk({req, " busy"}, busy, 1'b0);
        chk({req, " res_valid"}, res_valid, 1'b0);
        chk({req, " pu"}, drv_pu, 1'b0);
        chk({req, " pd"}, drv_pd, 1'b0);
        chk({req, " a"}, drv_a, 1'b0);
        chk({req, " wneg"}, drv_wneg, 1'b0);
        chk({req, " wpos"}, drv_wpos, 1'b0);
    endtask

    // Reference: per-cycle expected drives for one command (step kinds 1=write,2=pre,3=act,4=apply)
    task automatic do_cmd(logic w, logic b, logic e, logic a, bit intrude);
        int phases[$];
        @(negedge clk);
        cmd_valid = 1'b1; cmd_wr = w; cmd_b = b; cmd_ev = e; cmd_a = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (w) phases.push_back(1);
        if (e) begin phases.push_back(2); phases.push_back(3); phases.push_back(4); end
        for (int i = 0; i < phases.size() * S; i++) begin
            int ph;
            ph = phases[i / S];
            chk("R2/R7 busy", busy, 1'b1);
            chk("R2 res_valid early", res_valid, 1'b0);
            chk("R3 pu", drv_pu, ph == 2);
            chk("R3 pd", drv_pd, ph == 3 || ph == 4);
            chk("R11 a", drv_a, (ph == 4) ? a : 1'b0);
            chk("R4 wneg", drv_wneg, ph == 1 && b);
            chk("R4 wpos", drv_wpos, ph == 1 && !b);
            if (intrude && i == 0) begin
                cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_b = ~b; cmd_ev = 1'b0;
            end
            if (intrude && i == 1) cmd_valid = 1'b0;
            @(negedge clk);
        end
        if (w) model_b = b;
        chk("R7 busy in result cycle", busy, 1'b1);
        chk("R1 res_valid", res_valid, e);
        if (e) chk("R1/R6 res_data", res_data, ~(a & model_b));
        @(negedge clk);
        chk_quiet("R7 after result");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nneg, npos;
        bit order_ok, pu_early, busy_drop, got;
        logic res;
        repeat (3) @(negedge clk);
        chk_quiet("reset state");
        // R9/R5: release both resets and present an evaluate command at once
        por_n = 1'b1; rst_n = 1'b1;
        cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_ev = 1'b1; cmd_a = 1'b1;
        nneg = 0; npos = 0; order_ok = 1; pu_early = 0; busy_drop = 0; got = 0; res = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (drv_wneg) begin nneg++; if (npos > 0) order_ok = 0; end
            if (drv_wpos) npos++;
            if (drv_pu && npos < S) pu_early = 1;
            if (res_valid) begin got = 1; res = res_data; end
            else if (!busy) busy_drop = 1;
        end
        chk("R5 neg pulse cycles", nneg == S, 1'b1);
        chk("R5 pos pulse cycles", npos == S, 1'b1);
        chk("R5 neg before pos", order_ok, 1'b1);
        chk("R9 no precharge before init done", pu_early, 1'b0);
        chk("R7 busy held during hold-off", busy_drop, 1'b0);
        chk("R9 held command completed", got, 1'b1);
        chk("R5 stored 0 after init", res, 1'b1);
        model_b = 1'b0;
        @(negedge clk);

        do_cmd(1'b0, 1'b0, 1'b1, 1'b0, 0);   // R1: A=0,B=0
        do_cmd(1'b1, 1'b1, 1'b0, 1'b0, 0);   // R4: write B=1 only
        do_cmd(1'b0, 1'b0, 1'b1, 1'b1, 0);   // R1/R6: A=1,B=1 -> 0
        do_cmd(1'b0, 1'b0, 1'b1, 1'b0, 0);   // R8: B persists, A=0 -> 1
        do_cmd(1'b1, 1'b0, 1'b1, 1'b1, 0);   // R2: write B=0 then eval
        do_cmd(1'b1, 1'b1, 1'b1, 1'b1, 1);   // R7: intruding write ignored
        do_cmd(1'b0, 1'b0, 1'b1, 1'b1, 0);   // R7: B still 1 -> 0

        // R10: command with no flags is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_ev = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk_quiet("R10 nop");
            @(negedge clk);
        end

        // R8: controller reset keeps B=1 and skips conditioning
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 2 * S + 2; i++) begin
            @(negedge clk);
            chk_quiet("R8 no re-init after rst_n");
        end
        do_cmd(1'b0, 1'b0, 1'b1, 1'b1, 0);   // R8: still B=1 -> 0

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule